// File: doc/BRIEF.md
# Strided 2D Transfer Page Splitter

This block takes one rectangular transfer request and breaks it into a stream of contiguous pieces. No piece crosses a page boundary in system memory. A request names these values:

- the first system-memory byte and the first device (framebuffer) byte;
- the bytes per line and the number of lines;
- an unsigned memory stride and a signed device stride.

The block walks the rectangle line by line. It cuts a line wherever the memory side reaches a page edge. The device address moves forward by the same amount as the memory address. A negative device stride walks the device lines upward, which flips the image vertically.

Each piece leaves on a valid/ready output as a memory address, a device address, a byte length and a last flag. The stream is meant to feed the code that fills DMA descriptors. When the walk ends, the block gives a one-cycle completion pulse with the piece total and an error bit.

A count-only mode walks the same sequence silently and returns only the total, so descriptor storage can be sized before it is filled. Requests that break the size, stride or alignment limits are refused with the error bit and a total of zero. Such a request produces no pieces.

Top module: `bt_page_splitter`

## Requirements
- R1: Every piece length equals the smaller of the bytes still left in its line and the bytes from its memory address up to the next multiple of PAGE_BYTES (default 4096); each piece therefore lies inside one page.
- R2: Inside a line, each following piece starts at the previous memory address plus its length, and at the previous device address plus its length.
- R3: Each new line starts at the previous line's memory start plus the memory stride, and at the previous line's device start plus the sign-extended device stride; a negative device stride (down to minus the line length) is accepted.
- R4: seg_last is 1 only on the final piece of the request. One cycle after that piece is taken, done_valid is high for exactly one cycle with done_error = 0 and done_count equal to the number of pieces.
- R5: A request is refused when the line count is zero or negative, when the line length is zero or negative, or when the line count exceeds MAX_LINES (2048). A request of exactly 2048 lines is accepted.
- R6: A request is refused when the memory stride exceeds MAX_MEM_STRIDE (8192), or when the memory stride minus the line length is PAGE_BYTES or more. A stride of exactly 8192 is accepted.
- R7: A request is refused when the memory stride is below the line length, or when the magnitude of the device stride is below the line length.
- R8: A request is refused unless the memory address and memory stride are multiples of MEM_ALIGN (16) and the device address and device stride are multiples of DEV_ALIGN (4).
- R9: A refused request raises done_valid in the cycle after acceptance, with done_error = 1 and done_count = 0, and emits no piece.
- R10: With req_count_only = 1 at acceptance, seg_valid stays 0 for the whole request, pieces advance one per cycle, and done_count reports the same total as a normal walk.
- R11: While seg_valid is 1 and seg_ready is 0, the piece outputs hold their values into the next cycle.
- R12: After reset, and whenever no request is in progress, req_ready is 1 and seg_valid and done_valid are 0. req_ready is 0 while a request runs, and a req_valid pulse in that time is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block is idle and takes a request |
| req_count_only | input | 1 | Walk without emitting pieces; report total only |
| req_mem_addr | input | ADDR_W | First system-memory byte |
| req_dev_addr | input | ADDR_W | First device byte |
| req_line_len | input | LEN_W | Bytes per line (signed) |
| req_num_lines | input | LEN_W | Number of lines (signed) |
| req_mem_stride | input | LEN_W | Memory line pitch (signed) |
| req_dev_stride | input | LEN_W | Device line pitch (signed, may be negative) |
| seg_ready | input | 1 | Consumer takes the current piece |
| seg_valid | output | 1 | Piece outputs are valid |
| seg_mem_addr | output | ADDR_W | Piece memory address |
| seg_dev_addr | output | ADDR_W | Piece device address |
| seg_len | output | LEN_W | Piece length in bytes |
| seg_last | output | 1 | Final piece of the request |
| done_valid | output | 1 | One-cycle completion pulse |
| done_count | output | CNT_W | Piece total (0 when refused) |
| done_error | output | 1 | 1 when the request was refused |

## Verification
The assertions assume that PAGE_BYTES is a power of two smaller than 2 to the power LEN_W. They also assume that a request is presented only while req_ready is high. The stimulus holds req_valid for a single cycle at each idle point. It keeps every field within LEN_W signed range. It drives seg_ready from a fixed rotating pattern set between clock edges, so the hold property under backpressure is reached often. The one deliberate req_valid during a run is placed where req_ready is low.

// File: rtl/bt_split_pkg.sv
package bt_split_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } walk_state_t;
endpackage

// File: rtl/bt_req_check.sv
module bt_req_check #(
  parameter int LEN_W          = 16,
  parameter int PAGE_BYTES     = 4096,
  parameter int MAX_LINES      = 2048,
  parameter int MAX_MEM_STRIDE = 8192,
  parameter int MEM_ALIGN      = 16,
  parameter int DEV_ALIGN      = 4,
  localparam int MAB           = $clog2(MEM_ALIGN),
  localparam int DAB           = $clog2(DEV_ALIGN)
) (
  input  logic [MAB-1:0]   mem_lo,
  input  logic [DAB-1:0]   dev_lo,
  input  logic [LEN_W-1:0] line_len,
  input  logic [LEN_W-1:0] num_lines,
  input  logic [LEN_W-1:0] mem_stride,
  input  logic [LEN_W-1:0] dev_stride,
  output logic             reject
);
  localparam int EW = LEN_W + 2;
  localparam logic signed [EW-1:0] ZERO   = '0;
  localparam logic signed [EW-1:0] LIM_LN = EW'(MAX_LINES);
  localparam logic signed [EW-1:0] LIM_MS = EW'(MAX_MEM_STRIDE);
  localparam logic signed [EW-1:0] LIM_PG = EW'(PAGE_BYTES);

  logic signed [EW-1:0] len_x, lines_x, ms_x, ds_x, ds_mag, gap;
  logic size_bad, stride_bad, pitch_bad, align_bad;

  always_comb begin
    len_x   = {{2{line_len[LEN_W-1]}}, line_len};
    lines_x = {{2{num_lines[LEN_W-1]}}, num_lines};
    ms_x    = {{2{mem_stride[LEN_W-1]}}, mem_stride};
    ds_x    = {{2{dev_stride[LEN_W-1]}}, dev_stride};
    ds_mag  = ds_x[EW-1] ? -ds_x : ds_x;
    gap     = ms_x - len_x;

    size_bad   = (lines_x <= ZERO) || (len_x <= ZERO) || (lines_x > LIM_LN);
    stride_bad = (ms_x > LIM_MS) || (gap >= LIM_PG);
    pitch_bad  = (ms_x < len_x) || (ds_mag < len_x);
    align_bad  = (|mem_lo) || (|mem_stride[MAB-1:0]) ||
                 (|dev_lo) || (|dev_stride[DAB-1:0]);
    reject     = size_bad || stride_bad || pitch_bad || align_bad;
  end
endmodule

// File: rtl/bt_seg_walker.sv
module bt_seg_walker
  import bt_split_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int CNT_W      = 16,
  parameter int PAGE_BYTES = 4096,
  localparam int PB        = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              start_bad,
  input  logic              start_count_only,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic [ADDR_W-1:0] dev_addr,
  input  logic [LEN_W-1:0]  line_len,
  input  logic [LEN_W-1:0]  num_lines,
  input  logic [LEN_W-1:0]  mem_stride,
  input  logic [LEN_W-1:0]  dev_stride,
  output logic              idle,
  input  logic              seg_ready,
  output logic              seg_valid,
  output logic [ADDR_W-1:0] seg_mem,
  output logic [ADDR_W-1:0] seg_dev,
  output logic [LEN_W-1:0]  seg_len,
  output logic              seg_last,
  output logic              done_valid,
  output logic [CNT_W-1:0]  done_count,
  output logic              done_error
);
  localparam logic [LEN_W:0] PAGE_L = (LEN_W+1)'(PAGE_BYTES);

  function automatic logic [LEN_W-1:0] cut(input logic [PB-1:0] off,
                                           input logic [LEN_W-1:0] bytes);
    logic [LEN_W:0] room;
    room = PAGE_L - (LEN_W+1)'(off);
    if ({1'b0, bytes} < room) return bytes;
    else                      return room[LEN_W-1:0];
  endfunction

  walk_state_t state;
  logic              cnt_mode;
  logic [LEN_W-1:0]  seg_rem, lines_rem, len_r, ms_r, ds_r;
  logic [ADDR_W-1:0] line_mem, line_dev;
  logic [CNT_W-1:0]  count;

  logic [ADDR_W-1:0] nx_mem, nx_dev, nx_line_mem, nx_line_dev;
  logic [LEN_W-1:0]  nx_bytes, nx_len, nx_lines_rem;
  logic [LEN_W-1:0]  st_len;
  logic              fire;

  always_comb begin
    if (seg_rem != '0) begin
      nx_mem       = seg_mem + ADDR_W'(seg_len);
      nx_dev       = seg_dev + ADDR_W'(seg_len);
      nx_bytes     = seg_rem;
      nx_line_mem  = line_mem;
      nx_line_dev  = line_dev;
      nx_lines_rem = lines_rem;
    end else begin
      nx_line_mem  = line_mem + ADDR_W'(ms_r);
      nx_line_dev  = line_dev + {{(ADDR_W-LEN_W){ds_r[LEN_W-1]}}, ds_r};
      nx_mem       = nx_line_mem;
      nx_dev       = nx_line_dev;
      nx_bytes     = len_r;
      nx_lines_rem = lines_rem - LEN_W'(1);
    end
    nx_len = cut(nx_mem[PB-1:0], nx_bytes);
    st_len = cut(mem_addr[PB-1:0], line_len);
  end

  assign fire       = (state == ST_RUN) && (cnt_mode || seg_ready);
  assign idle       = (state == ST_IDLE);
  assign seg_valid  = (state == ST_RUN) && !cnt_mode;
  assign done_valid = (state == ST_DONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      cnt_mode   <= 1'b0;
      seg_mem    <= '0;
      seg_dev    <= '0;
      seg_len    <= '0;
      seg_rem    <= '0;
      seg_last   <= 1'b0;
      lines_rem  <= '0;
      len_r      <= '0;
      ms_r       <= '0;
      ds_r       <= '0;
      line_mem   <= '0;
      line_dev   <= '0;
      count      <= '0;
      done_count <= '0;
      done_error <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            count <= '0;
            if (start_bad) begin
              state      <= ST_DONE;
              done_error <= 1'b1;
              done_count <= '0;
            end else begin
              state     <= ST_RUN;
              cnt_mode  <= start_count_only;
              len_r     <= line_len;
              ms_r      <= mem_stride;
              ds_r      <= dev_stride;
              line_mem  <= mem_addr;
              line_dev  <= dev_addr;
              seg_mem   <= mem_addr;
              seg_dev   <= dev_addr;
              seg_len   <= st_len;
              seg_rem   <= line_len - st_len;
              lines_rem <= num_lines - LEN_W'(1);
              seg_last  <= (line_len == st_len) && (num_lines == LEN_W'(1));
            end
          end
        end
        ST_RUN: begin
          if (fire) begin
            count <= count + CNT_W'(1);
            if (seg_last) begin
              state      <= ST_DONE;
              done_error <= 1'b0;
              done_count <= count + CNT_W'(1);
            end else begin
              seg_mem   <= nx_mem;
              seg_dev   <= nx_dev;
              seg_len   <= nx_len;
              seg_rem   <= nx_bytes - nx_len;
              line_mem  <= nx_line_mem;
              line_dev  <= nx_line_dev;
              lines_rem <= nx_lines_rem;
              seg_last  <= (nx_bytes == nx_len) && (nx_lines_rem == '0);
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bt_page_splitter.sv
module bt_page_splitter #(
  parameter int ADDR_W         = 32,
  parameter int LEN_W          = 16,
  parameter int CNT_W          = 16,
  parameter int PAGE_BYTES     = 4096,
  parameter int MAX_LINES      = 2048,
  parameter int MAX_MEM_STRIDE = 8192,
  parameter int MEM_ALIGN      = 16,
  parameter int DEV_ALIGN      = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_count_only,
  input  logic [ADDR_W-1:0] req_mem_addr,
  input  logic [ADDR_W-1:0] req_dev_addr,
  input  logic [LEN_W-1:0]  req_line_len,
  input  logic [LEN_W-1:0]  req_num_lines,
  input  logic [LEN_W-1:0]  req_mem_stride,
  input  logic [LEN_W-1:0]  req_dev_stride,
  input  logic              seg_ready,
  output logic              seg_valid,
  output logic [ADDR_W-1:0] seg_mem_addr,
  output logic [ADDR_W-1:0] seg_dev_addr,
  output logic [LEN_W-1:0]  seg_len,
  output logic              seg_last,
  output logic              done_valid,
  output logic [CNT_W-1:0]  done_count,
  output logic              done_error
);
  localparam int MAB = $clog2(MEM_ALIGN);
  localparam int DAB = $clog2(DEV_ALIGN);

  logic bad, idle, start;

  assign req_ready = idle;
  assign start     = req_valid && idle;

  bt_req_check #(
    .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES), .MAX_LINES(MAX_LINES),
    .MAX_MEM_STRIDE(MAX_MEM_STRIDE), .MEM_ALIGN(MEM_ALIGN), .DEV_ALIGN(DEV_ALIGN)
  ) u_check (
    .mem_lo     (req_mem_addr[MAB-1:0]),
    .dev_lo     (req_dev_addr[DAB-1:0]),
    .line_len   (req_line_len),
    .num_lines  (req_num_lines),
    .mem_stride (req_mem_stride),
    .dev_stride (req_dev_stride),
    .reject     (bad)
  );

  bt_seg_walker #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .CNT_W(CNT_W), .PAGE_BYTES(PAGE_BYTES)
  ) u_walk (
    .clk              (clk),
    .rst              (rst),
    .start            (start),
    .start_bad        (bad),
    .start_count_only (req_count_only),
    .mem_addr         (req_mem_addr),
    .dev_addr         (req_dev_addr),
    .line_len         (req_line_len),
    .num_lines        (req_num_lines),
    .mem_stride       (req_mem_stride),
    .dev_stride       (req_dev_stride),
    .idle             (idle),
    .seg_ready        (seg_ready),
    .seg_valid        (seg_valid),
    .seg_mem          (seg_mem_addr),
    .seg_dev          (seg_dev_addr),
    .seg_len          (seg_len),
    .seg_last         (seg_last),
    .done_valid       (done_valid),
    .done_count       (done_count),
    .done_error       (done_error)
  );
endmodule

// File: rtl/bt_page_splitter_chk.sv
module bt_page_splitter_chk #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int CNT_W      = 16,
  parameter int PAGE_BYTES = 4096
) (
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic              seg_ready,
  input logic              seg_valid,
  input logic [ADDR_W-1:0] seg_mem_addr,
  input logic [ADDR_W-1:0] seg_dev_addr,
  input logic [LEN_W-1:0]  seg_len,
  input logic              seg_last,
  input logic              done_valid,
  input logic [CNT_W-1:0]  done_count,
  input logic              done_error
);
  localparam int PB = $clog2(PAGE_BYTES);
  localparam logic [LEN_W:0] PAGE_L = (LEN_W+1)'(PAGE_BYTES);

  // R1: a piece never runs past the page holding its first byte
  p_in_page_r1: assert property (@(posedge clk) disable iff (rst)
    seg_valid |-> (seg_len != '0) &&
      ({1'b0, seg_len} <= PAGE_L - (LEN_W+1)'(seg_mem_addr[PB-1:0])));

  // R11: stalled piece holds
  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    seg_valid && !seg_ready |=> seg_valid && $stable(seg_mem_addr) &&
      $stable(seg_dev_addr) && $stable(seg_len) && $stable(seg_last));

  // R12: idle means nothing is emitted
  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !seg_valid && !done_valid);

  // R4: completion is a single-cycle pulse followed by idle
  p_done_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    done_valid |=> !done_valid && req_ready);

  // R9: refusal reports zero pieces
  p_err_empty_r9: assert property (@(posedge clk) disable iff (rst)
    done_valid && done_error |-> done_count == '0);
endmodule

bind bt_page_splitter bt_page_splitter_chk #(
  .ADDR_W(ADDR_W), .LEN_W(LEN_W), .CNT_W(CNT_W), .PAGE_BYTES(PAGE_BYTES)
) u_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready), .seg_ready(seg_ready),
  .seg_valid(seg_valid), .seg_mem_addr(seg_mem_addr), .seg_dev_addr(seg_dev_addr),
  .seg_len(seg_len), .seg_last(seg_last), .done_valid(done_valid),
  .done_count(done_count), .done_error(done_error)
);

// File: tb/tb_bt_page_splitter.sv
module tb_bt_page_splitter;
  localparam int PAGE = 4096;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic        req_valid = 1'b0, req_count_only = 1'b0, seg_ready = 1'b0;
  logic        req_ready, seg_valid, seg_last, done_valid, done_error;
  logic [31:0] req_mem_addr = '0, req_dev_addr = '0, seg_mem_addr, seg_dev_addr;
  logic [15:0] req_line_len = '0, req_num_lines = '0, req_mem_stride = '0, req_dev_stride = '0;
  logic [15:0] seg_len, done_count;

  bt_page_splitter dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_count_only(req_count_only), .req_mem_addr(req_mem_addr),
    .req_dev_addr(req_dev_addr), .req_line_len(req_line_len),
    .req_num_lines(req_num_lines), .req_mem_stride(req_mem_stride),
    .req_dev_stride(req_dev_stride), .seg_ready(seg_ready), .seg_valid(seg_valid),
    .seg_mem_addr(seg_mem_addr), .seg_dev_addr(seg_dev_addr), .seg_len(seg_len),
    .seg_last(seg_last), .done_valid(done_valid), .done_count(done_count),
    .done_error(done_error)
  );

  typedef struct packed {
    logic [31:0]        mem;
    logic [31:0]        dev;
    logic signed [15:0] len;
    logic signed [15:0] lines;
    logic signed [15:0] ms;
    logic signed [15:0] ds;
    logic               cmode;
    logic [15:0]        cnt;
    logic               err;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{32'h1000, 32'h0,     16'sd64,   16'sd4,    16'sd64,   16'sd64,   1'b0, 16'd4,    1'b0},
    '{32'h1FF0, 32'h100,   16'sd32,   16'sd1,    16'sd32,   16'sd32,   1'b0, 16'd2,    1'b0},
    '{32'h0F80, 32'h10000, 16'sd256,  16'sd3,    16'sd256,  -16'sd256, 1'b0, 16'd4,    1'b0},
    '{32'h1000, 32'h0,     16'sd64,   16'sd0,    16'sd64,   16'sd64,   1'b0, 16'd0,    1'b1},
    '{32'h1000, 32'h0,     -16'sd4,   16'sd2,    16'sd64,   16'sd64,   1'b0, 16'd0,    1'b1},
    '{32'h0,    32'h0,     16'sd16,   16'sd2049, 16'sd16,   16'sd16,   1'b0, 16'd0,    1'b1},
    '{32'h0,    32'h0,     16'sd8208, 16'sd1,    16'sd8208, 16'sd8208, 1'b0, 16'd0,    1'b1},
    '{32'h0,    32'h0,     16'sd64,   16'sd2,    16'sd4160, 16'sd64,   1'b0, 16'd0,    1'b1},
    '{32'h0,    32'h0,     16'sd64,   16'sd2,    16'sd4144, 16'sd64,   1'b0, 16'd2,    1'b0},
    '{32'h0,    32'h0,     16'sd64,   16'sd2,    16'sd48,   16'sd64,   1'b0, 16'd0,    1'b1},
    '{32'h0,    32'h0,     16'sd64,   16'sd2,    16'sd64,   -16'sd32,  1'b0, 16'd0,    1'b1},
    '{32'h1008, 32'h0,     16'sd16,   16'sd1,    16'sd16,   16'sd16,   1'b0, 16'd0,    1'b1},
    '{32'h0,    32'h2,     16'sd16,   16'sd1,    16'sd16,   16'sd16,   1'b0, 16'd0,    1'b1},
    '{32'h0,    32'h0,     16'sd16,   16'sd2,    16'sd16,   16'sd18,   1'b0, 16'd0,    1'b1},
    '{32'h0,    32'h0,     16'sd16,   16'sd2,    16'sd24,   16'sd16,   1'b0, 16'd0,    1'b1},
    '{32'h0F80, 32'h10000, 16'sd256,  16'sd3,    16'sd256,  -16'sd256, 1'b1, 16'd4,    1'b0},
    '{32'h0,    32'h0,     16'sd16,   16'sd2048, 16'sd16,   16'sd16,   1'b0, 16'd2048, 1'b0},
    '{32'h10,   32'h40,    16'sd8192, 16'sd1,    16'sd8192, 16'sd8192, 1'b0, 16'd3,    1'b0}
  };

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  function automatic string tag_of(input int i);
    case (i)
      0: return "R2"; 1: return "R1"; 2: return "R3";
      3, 4, 5, 16: return "R5"; 6, 7, 8, 17: return "R6";
      9, 10: return "R7"; 11, 12, 13, 14: return "R8";
      15: return "R10";
      default: return "R4";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v, input int idx, input bit poke);
    logic [31:0] lm, ld, cm, cd;
    int left, ml, nseg, cyc, room, el;
    bit fin, elast, rdy;
    @(negedge clk);
    chk(req_ready === 1'b1, "R12", "ready before request", longint'(req_ready), 1);
    req_mem_addr = v.mem; req_dev_addr = v.dev; req_line_len = v.len;
    req_num_lines = v.lines; req_mem_stride = v.ms; req_dev_stride = v.ds;
    req_count_only = v.cmode; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    lm = v.mem; ld = v.dev; cm = lm; cd = ld; left = int'(v.len); ml = 0;
    nseg = 0; cyc = 0; fin = 1'b0;
    while (!fin && cyc < 20000) begin
      if (poke && cyc == 1) begin
        chk(req_ready === 1'b0, "R12", "ready while running", longint'(req_ready), 0);
        req_mem_addr = 32'h8; req_line_len = 16'sd4; req_valid = 1'b1;
      end else begin
        req_valid = 1'b0;
      end
      if (done_valid) begin
        chk(done_error === v.err, tag_of(idx), "done_error", longint'(done_error), longint'(v.err));
        chk(done_count === v.cnt, v.err ? "R9" : "R4", "done_count", longint'(done_count), longint'(v.cnt));
        fin = 1'b1;
      end else begin
        rdy = ((cyc + idx) % 4) != 3;
        if (seg_valid) begin
          if (v.cmode || v.err) begin
            chk(1'b0, v.cmode ? "R10" : "R9", "unexpected seg_valid", 1, 0);
          end else begin
            room = PAGE - int'(cm % PAGE);
            el = (left < room) ? left : room;
            elast = (left == el) && (ml == int'(v.lines) - 1);
            chk(seg_len == 16'(el), "R1", "seg_len", longint'(seg_len), longint'(el));
            chk(seg_mem_addr == cm, "R2", "seg_mem_addr", longint'(seg_mem_addr), longint'(cm));
            chk(seg_dev_addr == cd, "R3", "seg_dev_addr", longint'(seg_dev_addr), longint'(cd));
            chk(seg_last == elast, "R4", "seg_last", longint'(seg_last), longint'(elast));
            if (rdy) begin
              nseg++;
              cm = cm + 32'(el); cd = cd + 32'(el); left = left - el;
              if (left == 0) begin
                ml++;
                lm = lm + 32'(v.ms);
                ld = ld + {{16{v.ds[15]}}, v.ds};
                cm = lm; cd = ld; left = int'(v.len);
              end
            end
          end
        end
        seg_ready = rdy;
        @(negedge clk);
        cyc++;
      end
    end
    req_valid = 1'b0;
    chk(fin, "R4", "completion seen", longint'(fin), 1);
    if (!v.cmode && !v.err)
      chk(nseg == int'(v.cnt), "R4", "pieces taken", longint'(nseg), longint'(v.cnt));
    if (v.cmode)
      chk(nseg == 0, "R10", "pieces taken in count mode", longint'(nseg), 0);
    @(negedge clk);
    chk(req_ready && !seg_valid && !done_valid, "R12", "idle after done",
        longint'({req_ready, seg_valid, done_valid}), 3'b100);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(req_ready === 1'b1, "R12", "reset req_ready", longint'(req_ready), 1);
    chk(seg_valid === 1'b0, "R12", "reset seg_valid", longint'(seg_valid), 0);
    chk(done_valid === 1'b0, "R12", "reset done_valid", longint'(done_valid), 0);
    for (int i = 0; i < NV; i++) run_vec(VECS[i], i, 1'b0);
    // directed: request pulse while busy must be ignored (R12), backpressure (R11)
    run_vec(VECS[0], 1, 1'b1);
    run_vec(VECS[2], 3, 1'b0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL R4 watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule